// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit does lane-parallel integer arithmetic on two 64-bit packed operands. A lane-size code splits each operand into eight 8-bit, four 16-bit or two 32-bit lanes. The selected operation then runs on every lane independently, and no carry or borrow crosses a lane edge. The available operations are wrap-around add and subtract, signed saturating add and subtract, and unsigned saturating add and subtract. Three bitwise operations (AND, OR, XOR) and a 64-bit move act on the whole word and take no notice of the lane size.

Operations enter on a valid/ready stream and leave on another. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result sits in the output register from the next cycle, with `out_valid` set. The output holds its value until the consumer takes it with `out_ready`. While a result waits and `out_ready` is low, `in_ready` stays low, so the producer must keep its request stable until it is accepted. A new operation can be accepted in the same cycle that the previous result is consumed. An unknown operation code, or a lane-size code that an arithmetic operation cannot use, produces a zero result marked by an illegal-operation flag.

Top module: `simd_alu`

## Requirements
- R1: Op codes 0 (add) and 1 (subtract, `in_a` minus `in_b`) wrap modulo 2^lane width in each lane, with no carry or borrow into the next lane. The lane-size codes are 0 for 8-bit lanes, 1 for 16-bit lanes and 2 for 32-bit lanes, and lane i occupies bits [i*w +: w].
- R2: Op codes 2 (add) and 3 (subtract) treat lanes as two's-complement values. A lane whose true result is out of range is clamped to the most positive value (0x7F.., sign bit clear) or the most negative value (0x80..).
- R3: Op codes 4 (add) and 5 (subtract) treat lanes as unsigned values. An add that overflows clamps to all ones, and a subtract that would go below zero clamps to zero.
- R4: Op codes 6, 7 and 8 give the bitwise AND, OR and XOR of the two operands over all 64 bits, for every lane-size code including 3.
- R5: Op code 9 copies `in_b` to the result unchanged, for any lane-size code and any `in_a`.
- R6: An accepted operation shows up on `out_data`/`out_illegal` with `out_valid` high on the cycle after the accepting edge. If nothing is accepted while `out_ready` is high, `out_valid` falls.
- R7: When `out_valid` is high and `out_ready` is low, `in_ready` is low, no input is taken, and `out_data`, `out_illegal` and `out_valid` hold their values.
- R8: Op codes 10 to 15, and arithmetic op codes 0 to 5 with lane-size code 3, give `out_data` = 0 and `out_illegal` = 1. Every legal operation gives `out_illegal` = 0.
- R9: While `rst` is high, at a clock edge `out_valid`, `out_data` and `out_illegal` all go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_op | input | 4 | Operation code |
| in_lsz | input | 2 | Lane-size code |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Packed result |
| out_illegal | output | 1 | Result came from an illegal operation |

## Verification
The bench puts values on lane edges: 0xFF plus 1 in every byte, and 0x8000 minus 1 in words. A carry chain that was not cut would corrupt the neighbouring lane. It drives signed and unsigned saturation in both directions at every lane size. A design that mixed up the signed and unsigned overflow tests would clamp the wrong cases, and one that picked the wrong clamp value would return 0x80 where 0x7F belongs. A stalled consumer checks that the held result is not overwritten by a request that is still waiting. Illegal codes, including arithmetic with lane-size 3, catch a decoder that lets those operations through or leaves the flag set on the next legal result.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDSS = 4'd2,
    OP_SUBSS = 4'd3,
    OP_ADDUS = 4'd4,
    OP_SUBUS = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_MOV   = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LSZ_8   = 2'd0,
    LSZ_16  = 2'd1,
    LSZ_32  = 2'd2,
    LSZ_BAD = 2'd3
  } lane_sz_e;

  // Controls shared by all lane adders
  typedef struct packed {
    logic sub;  // invert b and add one
    logic sat;  // clamp on overflow
    logic sgn;  // two's-complement overflow rule
  } arith_ctl_t;

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
  import simd_alu_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  arith_ctl_t    ctl_i,
  output logic [DW-1:0] y_o
);

  localparam int NL = DW / LW;
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] la, lb, lbx, lres;
    logic [LW:0]   sum;
    logic          ovf_s;

    assign la  = a_i[g*LW +: LW];
    assign lb  = b_i[g*LW +: LW];
    assign lbx = ctl_i.sub ? ~lb : lb;
    // The adder is only LW+1 wide, so a carry cannot leave the lane
    assign sum = {1'b0, la} + {1'b0, lbx} + {{LW{1'b0}}, ctl_i.sub};
    assign ovf_s = (la[LW-1] == lbx[LW-1]) && (sum[LW-1] != la[LW-1]);

    always_comb begin
      lres = sum[LW-1:0];
      if (ctl_i.sat) begin
        if (ctl_i.sgn) begin
          if (ovf_s) lres = la[LW-1] ? SMIN : SMAX;
        end else if (sum[LW] != ctl_i.sub) begin
          lres = ctl_i.sub ? '0 : '1;
        end
      end
    end

    assign y_o[g*LW +: LW] = lres;
  end

endmodule

// File: rtl/simd_alu_core.sv
module simd_alu_core
  import simd_alu_pkg::*;
#(
  parameter int DW   = 64,
  parameter int MINW = 8,
  parameter int NSZ  = 3
) (
  input  logic [3:0]    op_i,
  input  logic [1:0]    lsz_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          ill_o
);

  arith_ctl_t    ctl;
  logic          is_arith;
  logic [DW-1:0] ar_res [NSZ];

  always_comb begin
    ctl      = '0;
    is_arith = 1'b1;
    case (alu_op_e'(op_i))
      OP_ADD:   ctl = '{sub: 1'b0, sat: 1'b0, sgn: 1'b0};
      OP_SUB:   ctl = '{sub: 1'b1, sat: 1'b0, sgn: 1'b0};
      OP_ADDSS: ctl = '{sub: 1'b0, sat: 1'b1, sgn: 1'b1};
      OP_SUBSS: ctl = '{sub: 1'b1, sat: 1'b1, sgn: 1'b1};
      OP_ADDUS: ctl = '{sub: 1'b0, sat: 1'b1, sgn: 1'b0};
      OP_SUBUS: ctl = '{sub: 1'b1, sat: 1'b1, sgn: 1'b0};
      default:  is_arith = 1'b0;
    endcase
  end

  // One lane array per lane width: MINW, 2*MINW, 4*MINW ...
  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    simd_lane_arith #(
      .DW(DW),
      .LW(MINW << k)
    ) u_lanes (
      .a_i  (a_i),
      .b_i  (b_i),
      .ctl_i(ctl),
      .y_o  (ar_res[k])
    );
  end

  always_comb begin
    res_o = '0;
    ill_o = 1'b0;
    if (is_arith) begin
      case (lane_sz_e'(lsz_i))
        LSZ_8:   res_o = ar_res[0];
        LSZ_16:  res_o = ar_res[1];
        LSZ_32:  res_o = ar_res[2];
        default: ill_o = 1'b1;
      endcase
    end else begin
      case (alu_op_e'(op_i))
        OP_AND:  res_o = a_i & b_i;
        OP_OR:   res_o = a_i | b_i;
        OP_XOR:  res_o = a_i ^ b_i;
        OP_MOV:  res_o = b_i;
        default: ill_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [1:0]    in_lsz,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_illegal
);

  localparam int MINW = 8;
  localparam int NSZ  = 3;

  logic [DW-1:0] c_res;
  logic          c_ill;
  logic          accept;

  simd_alu_core #(
    .DW  (DW),
    .MINW(MINW),
    .NSZ (NSZ)
  ) u_core (
    .op_i (in_op),
    .lsz_i(in_lsz),
    .a_i  (in_a),
    .b_i  (in_b),
    .res_o(c_res),
    .ill_o(c_ill)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= c_res;
      out_illegal <= c_ill;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_op,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_illegal
);

  p_accept_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));

  p_and_whole_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 4'd6) |=> (out_data == $past(in_a & in_b)));

  p_move_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 4'd9) |=> (out_data == $past(in_b) && !out_illegal));

  p_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op > 4'd9) |=> out_illegal);

  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_data == '0));

endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_illegal(out_illegal)
);

// File: tb/simd_alu_tb_top.sv
module simd_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_op;
  logic [1:0]  in_lsz;
  logic [63:0] in_a, in_b;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic        out_illegal;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  simd_alu dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_lsz(in_lsz), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic [1:0] sz);
    if (op > 4'd9 || (op <= 4'd5 && sz == 2'd3)) return "R8";
    if (op <= 4'd1) return "R1";
    if (op <= 4'd3) return "R2";
    if (op <= 4'd5) return "R3";
    if (op <= 4'd8) return "R4";
    return "R5";
  endfunction

  // Behavioural lane-by-lane reference
  function automatic void ref_calc(input logic [3:0] op, input logic [1:0] sz,
                                   input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] r, output logic ill);
    r = '0;
    ill = 1'b0;
    if (op > 4'd9 || (op <= 4'd5 && sz == 2'd3)) begin
      ill = 1'b1;
      return;
    end
    case (op)
      4'd6: r = a & b;
      4'd7: r = a | b;
      4'd8: r = a ^ b;
      4'd9: r = b;
      default: begin
        int w = 8 << sz;
        int n = 64 / w;
        longint m = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        for (int i = 0; i < n; i++) begin
          longint x, y, sx, sy, s;
          x  = longint'(a >> (i * w)) & m;
          y  = longint'(b >> (i * w)) & m;
          sx = (x >= half) ? x - (m + 1) : x;
          sy = (y >= half) ? y - (m + 1) : y;
          case (op)
            4'd0: s = x + y;
            4'd1: s = x - y;
            4'd2: begin
              s = sx + sy;
              if (s > half - 1) s = half - 1;
              if (s < -half) s = -half;
            end
            4'd3: begin
              s = sx - sy;
              if (s > half - 1) s = half - 1;
              if (s < -half) s = -half;
            end
            4'd4: begin
              s = x + y;
              if (s > m) s = m;
            end
            default: begin
              s = x - y;
              if (s < 0) s = 0;
            end
          endcase
          r = r | (64'(s & m) << (i * w));
        end
      end
    endcase
  endfunction

  // Cycle model of the output stage
  logic        m_valid = 1'b0;
  logic [63:0] m_data = '0;
  logic        m_ill = 1'b0;
  string       m_tag = "R9";
  logic [63:0] m_r;
  logic        m_il;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_ill   <= 1'b0;
      m_tag   <= "R9";
    end else if (in_valid && (!m_valid || out_ready)) begin
      ref_calc(in_op, in_lsz, in_a, in_b, m_r, m_il);
      m_valid <= 1'b1;
      m_data  <= m_r;
      m_ill   <= m_il;
      m_tag   <= tag_of(in_op, in_lsz);
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  // Compare on every clock, half a period after the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      chk("R6 out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid) begin
        chk({m_tag, " data"}, out_data, m_data);
        chk({m_tag, " flag"}, 64'(out_illegal), 64'(m_ill));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic run(input logic [3:0] op, input logic [1:0] sz,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic [63:0] exp, input logic exp_ill, input string tag);
    in_op = op; in_lsz = sz; in_a = a; in_b = b; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    chk({tag, " data"}, out_data, exp);
    chk({tag, " flag"}, 64'(out_illegal), 64'(exp_ill));
  endtask

  function automatic logic [63:0] pick64();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) begin
      case ($urandom % 6)
        0: v[k*8 +: 8] = 8'h00;
        1: v[k*8 +: 8] = 8'h7F;
        2: v[k*8 +: 8] = 8'h80;
        3: v[k*8 +: 8] = 8'hFF;
        default: v[k*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_lsz = '0;
    in_a = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) tick();
    chk("R9 out_valid", 64'(out_valid), 64'd0);
    chk("R9 out_data", out_data, 64'd0);
    chk("R9 out_illegal", 64'(out_illegal), 64'd0);
    rst = 1'b0;
    tick();

    // R1 wrap-around, lane edges
    run(4'd0, 2'd0, 64'hFF01_80FF_7F00_FF10, 64'h0101_8001_0100_0110, 64'h0002_0000_8000_0020, 1'b0, "R1 byte add");
    run(4'd1, 2'd1, 64'h0000_0005_8000_1234, 64'h0001_0003_0001_0234, 64'hFFFF_0002_7FFF_1000, 1'b0, "R1 word sub");
    run(4'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 64'h0000_0000_0000_0003, 1'b0, "R1 dword add");
    // R2 signed saturation
    run(4'd2, 2'd1, 64'h7FFF_8000_0001_FFFF, 64'h0001_FFFF_0002_FFFF, 64'h7FFF_8000_0003_FFFE, 1'b0, "R2 word add");
    run(4'd3, 2'd0, 64'h807F_0005_0000_0000, 64'h01FF_0103_0000_0000, 64'h807F_FF02_0000_0000, 1'b0, "R2 byte sub");
    run(4'd2, 2'd2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, 64'h7FFF_FFFF_8000_0000, 1'b0, "R2 dword add");
    // R3 unsigned saturation
    run(4'd4, 2'd0, 64'hFF80_0100_0000_0000, 64'h0180_0100_0000_0000, 64'hFFFF_0200_0000_0000, 1'b0, "R3 byte add");
    run(4'd5, 2'd2, 64'h0000_0001_8000_0000, 64'h0000_0002_7FFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, "R3 dword sub");
    // R4 bitwise, lane size ignored
    run(4'd6, 2'd3, 64'hF0F0_F0F0_1234_5678, 64'hFF00_FF00_0F0F_FFFF, 64'hF000_F000_0204_5678, 1'b0, "R4 and");
    run(4'd7, 2'd0, 64'h00FF_0000_0000_0001, 64'hFF00_0000_0000_0001, 64'hFFFF_0000_0000_0001, 1'b0, "R4 or");
    run(4'd8, 2'd2, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_5555_AAAA, 1'b0, "R4 xor");
    // R5 move
    run(4'd9, 2'd3, 64'h1111_1111_1111_1111, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 1'b0, "R5 move");
    // R8 illegal codes
    run(4'd15, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'd0, 1'b1, "R8 bad op");
    run(4'd0, 2'd3, 64'h1234, 64'h1, 64'd0, 1'b1, "R8 bad size");
    run(4'd0, 2'd0, 64'h01, 64'h01, 64'h02, 1'b0, "R8 flag clears");

    // R6 drain, then R7 stall
    tick();
    chk("R6 drained", 64'(out_valid), 64'd0);
    out_ready = 1'b0;
    run(4'd6, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 64'h1234, 1'b0, "R7 first");
    in_op = 4'd9; in_b = 64'h5555; in_valid = 1'b1;
    #1;
    chk("R7 not ready", 64'(in_ready), 64'd0);
    tick();
    chk("R7 held data", out_data, 64'h1234);
    chk("R7 held valid", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    tick();
    chk("R7 still held", out_data, 64'h1234);
    out_ready = 1'b1;
    tick();
    chk("R6 consumed", 64'(out_valid), 64'd0);

    // Mixed traffic with random stalls, compared by the model
    for (int i = 0; i < 4000; i++) begin
      in_valid  = ($urandom % 3) != 0;
      in_op     = 4'($urandom % 12);
      in_lsz    = 2'($urandom);
      in_a      = ($urandom % 2) ? pick64() : {$urandom, $urandom};
      in_b      = ($urandom % 2) ? pick64() : {$urandom, $urandom};
      out_ready = ($urandom % 4) != 0;
      tick();
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule